// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch status of every hardware thread in a multithreaded front end and moves it forward once per clock. Each cycle it takes in block and release pulses from four downstream stages, squash requests with a new target address from the commit and decode stages, a flag saying the reorder buffer is still flushing, a global context-switch flag, line-request issue events from the fetch datapath, and instruction-cache responses. From these it produces the next status of each thread.

For each thread it holds four sticky stall bits, the current fetch address and the next sequential address, and the tag of the one cache request that may be outstanding. The events that change a thread's status are applied in a fixed priority order. A cache response moves a thread only if the thread is waiting, the tag matches and no squash arrives in the same cycle. Any other response is thrown away and counted. The block also reports two things: whether any status changed at the last clock edge, and whether the stage as a whole has work to do.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Reset sets every thread to Running (code 0), with fetch address `RESET_PC`, next address `RESET_PC`+4, all stall bits clear, the drop count at zero and the change flag low. The status codes are Running=0, Idle=1, Squashing=2, Blocked=3, CacheWait=4, CacheDone=5, TrapWait=6, QuiesceWait=7.
- R2: A thread's stall bits are bit 0 decode, bit 1 rename, bit 2 execute and bit 3 commit. A block pulse sets that stage's bit and the bit stays set until a release pulse for the same stage clears it. A release may only come while the bit is set and that stage is not also blocking. A thread counts as stalled when the context-switch flag is high or any of its bits is set, and this uses the bit values after this cycle's pulses. `stalled_o` shows the OR of the thread's registered bits.
- R3: A commit squash has the top priority. At the next edge it loads the target as the fetch address, loads target+4 as the next address, and sets the status to Squashing.
- R4: When there is no commit squash, a reorder-buffer-busy flag puts the thread into Squashing, or keeps it there.
- R5: When neither of the above applies, a decode squash loads the target and target+4 and enters Squashing. If the thread is already Squashing, the decode squash is ignored and the address is left unchanged.
- R6: When none of the above applies, a stalled thread goes to Blocked. A thread in CacheWait stays in CacheWait even while stalled.
- R7: When none of the above applies, a thread in Blocked or Squashing returns to Running.
- R8: A Running thread that gets an issue pulse goes to CacheWait and records the issue tag. A CacheDone thread that gets a line-taken pulse goes back to Running.
- R9: A response accepted for a CacheWait thread sends that thread to Blocked if it is stalled, and to CacheDone otherwise. A response is accepted only if its thread index matches, its tag matches and the thread has no squash or busy flag in that cycle.
- R10: A squash while a thread is in CacheWait abandons the outstanding request. Any response that is not accepted, including a late one for an abandoned request, leaves all thread states unchanged and increments the drop count. The drop count stops at its maximum value.
- R11: `stage_active_o` is high whenever at least one thread is in Running, Squashing or CacheDone.
- R12: `status_chg_o` is high in the cycle after an edge at which at least one thread's status code changed, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_switch_i | input | 1 | Context switch in progress; stalls every thread |
| stage_block_i | input | NT*4 | Block pulse per thread and stage |
| stage_release_i | input | NT*4 | Release pulse per thread and stage |
| cmt_squash_i | input | NT | Commit squash per thread |
| cmt_target_i | input | NT*PC_W | Commit redirect address per thread |
| rob_busy_i | input | NT | Reorder buffer still flushing, per thread |
| dec_squash_i | input | NT | Decode squash per thread |
| dec_target_i | input | NT*PC_W | Decode redirect address per thread |
| issue_i | input | NT | Line request sent, per thread |
| issue_tag_i | input | NT*TAG_W | Tag of the request sent |
| line_taken_i | input | NT | Returned line consumed, per thread |
| rsp_valid_i | input | 1 | Cache response present |
| rsp_tid_i | input | TID_W | Thread index of the response |
| rsp_tag_i | input | TAG_W | Tag of the response |
| status_o | output | NT*3 | Status code per thread |
| pc_o | output | NT*PC_W | Fetch address per thread |
| npc_o | output | NT*PC_W | Next sequential address per thread |
| stalled_o | output | NT | Any sticky stall bit set, per thread |
| status_chg_o | output | 1 | A status changed at the last edge |
| stage_active_o | output | 1 | Some thread has fetch work |
| drop_cnt_o | output | CNT_W | Saturating count of dropped responses |

## Verification
The assertions assume the neighbours behave as R2 requires: a stage releases a thread only while that stage's bit is set, and never blocks and releases the same stage in one cycle. The stimulus sends a release only after the matching block has been seen, and it uses the context-switch flag for the stalls that come and go in the sweep. The bench also issues a request only from Running and sends at most one response per cycle, so each assertion sees only those input patterns.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NSTAGE     = 4;
  localparam int INST_BYTES = 4;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SQUASH  = 3'd2,
    ST_BLOCK   = 3'd3,
    ST_CWAIT   = 3'd4,
    ST_CDONE   = 3'd5,
    ST_TRAP    = 3'd6,
    ST_QUIESCE = 3'd7
  } fstat_e;
endpackage

// File: rtl/fsc_stall_track.sv
module fsc_stall_track
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_i,
  input  logic [NSTAGE-1:0] block_i,
  input  logic [NSTAGE-1:0] release_i,
  output logic [NSTAGE-1:0] bits_o,
  output logic              stalled_nxt_o
);
  logic [NSTAGE-1:0] bits_q;
  logic [NSTAGE-1:0] bits_d;
  logic [NSTAGE-1:0] bits_en;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    always_comb begin
      bits_en[s] = block_i[s] | release_i[s];
      bits_d[s]  = block_i[s] ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bits_q[s] <= 1'b0;
      else if (bits_en[s]) bits_q[s] <= bits_d[s];
    end
  end

  always_comb begin
    stalled_nxt_o = ctx_i;
    for (int s = 0; s < NSTAGE; s++) begin
      stalled_nxt_o = stalled_nxt_o | (bits_en[s] ? bits_d[s] : bits_q[s]);
    end
  end

  assign bits_o = bits_q;

  assert_release_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i != '0) |-> (((release_i & ~bits_q) == '0) && ((release_i & block_i) == '0)));

  assert_block_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (block_i != '0) |=> ((bits_q & $past(block_i)) == $past(block_i)));
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stalled_i,
  input  logic             cmt_sq_i,
  input  logic [PC_W-1:0]  cmt_pc_i,
  input  logic             rob_i,
  input  logic             dec_sq_i,
  input  logic [PC_W-1:0]  dec_pc_i,
  input  logic             issue_i,
  input  logic [TAG_W-1:0] issue_tag_i,
  input  logic             take_i,
  input  logic             rsp_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  output fstat_e           status_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  npc_o,
  output logic             accept_o,
  output logic             changed_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  fstat_e           st_q, st_d;
  logic [PC_W-1:0]  pc_q, npc_q, pc_d;
  logic [TAG_W-1:0] tag_q;
  logic             pc_en, tag_en, st_en;

  always_comb begin
    st_d     = st_q;
    pc_d     = pc_q;
    pc_en    = 1'b0;
    tag_en   = 1'b0;
    accept_o = 1'b0;
    if (cmt_sq_i) begin
      st_d  = ST_SQUASH;
      pc_d  = cmt_pc_i;
      pc_en = 1'b1;
    end else if (rob_i) begin
      st_d = ST_SQUASH;
    end else if (dec_sq_i && (st_q != ST_SQUASH)) begin
      st_d  = ST_SQUASH;
      pc_d  = dec_pc_i;
      pc_en = 1'b1;
    end else if (stalled_i && (st_q != ST_CWAIT)) begin
      st_d = ST_BLOCK;
    end else if ((st_q == ST_BLOCK) || (st_q == ST_SQUASH)) begin
      st_d = ST_RUN;
    end else if ((st_q == ST_CWAIT) && rsp_i && (rsp_tag_i == tag_q)) begin
      accept_o = 1'b1;
      st_d     = stalled_i ? ST_BLOCK : ST_CDONE;
    end else if ((st_q == ST_RUN) && issue_i) begin
      st_d   = ST_CWAIT;
      tag_en = 1'b1;
    end else if ((st_q == ST_CDONE) && take_i) begin
      st_d = ST_RUN;
    end
    st_en     = (st_d != st_q);
    changed_o = st_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_RUN;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      npc_q <= RESET_PC + STEP;
    end else if (pc_en) begin
      pc_q  <= pc_d;
      npc_q <= pc_d + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_en) tag_q <= issue_tag_i;
  end

  assign status_o = st_q;
  assign pc_o     = pc_q;
  assign npc_o    = npc_q;

  assert_cmt_squash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_sq_i |=> ((st_q == ST_SQUASH) && (pc_q == $past(cmt_pc_i)) &&
                  (npc_q == $past(cmt_pc_i) + STEP)));

  assert_rob_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_i && !cmt_sq_i) |=> (st_q == ST_SQUASH));

  assert_wait_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_CWAIT) && !cmt_sq_i && !rob_i && !dec_sq_i && !accept_o) |=> (st_q == ST_CWAIT));

  assert_accept_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> ((st_q == ST_BLOCK) || (st_q == ST_CDONE)));
endmodule

// File: rtl/fsc_drop_count.sv
module fsc_drop_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  assign cnt_en = drop_i && (cnt_q != {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_drop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_i && (cnt_q != {CNT_W{1'b1}})) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_drop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_i |=> $stable(cnt_q));
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int NT    = 2,
  parameter int PC_W  = 32,
  parameter int TAG_W = 4,
  parameter int CNT_W = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctx_switch_i,
  input  logic [NT*NSTAGE-1:0]  stage_block_i,
  input  logic [NT*NSTAGE-1:0]  stage_release_i,
  input  logic [NT-1:0]         cmt_squash_i,
  input  logic [NT*PC_W-1:0]    cmt_target_i,
  input  logic [NT-1:0]         rob_busy_i,
  input  logic [NT-1:0]         dec_squash_i,
  input  logic [NT*PC_W-1:0]    dec_target_i,
  input  logic [NT-1:0]         issue_i,
  input  logic [NT*TAG_W-1:0]   issue_tag_i,
  input  logic [NT-1:0]         line_taken_i,
  input  logic                  rsp_valid_i,
  input  logic [TID_W-1:0]      rsp_tid_i,
  input  logic [TAG_W-1:0]      rsp_tag_i,
  output logic [NT*3-1:0]       status_o,
  output logic [NT*PC_W-1:0]    pc_o,
  output logic [NT*PC_W-1:0]    npc_o,
  output logic [NT-1:0]         stalled_o,
  output logic                  status_chg_o,
  output logic                  stage_active_o,
  output logic [CNT_W-1:0]      drop_cnt_o
);
  logic [NT-1:0] accept;
  logic [NT-1:0] changed;
  logic [NT-1:0] thr_active;
  logic          chg_q;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [NSTAGE-1:0] bits;
    logic              stalled_nxt;
    logic              rsp_here;
    fstat_e            st;

    fsc_stall_track u_stall (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctx_i         (ctx_switch_i),
      .block_i       (stage_block_i[t*NSTAGE +: NSTAGE]),
      .release_i     (stage_release_i[t*NSTAGE +: NSTAGE]),
      .bits_o        (bits),
      .stalled_nxt_o (stalled_nxt)
    );

    assign rsp_here = rsp_valid_i && (rsp_tid_i == TID_W'(t));

    fsc_thread_fsm #(
      .PC_W     (PC_W),
      .TAG_W    (TAG_W),
      .RESET_PC (RESET_PC)
    ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .stalled_i   (stalled_nxt),
      .cmt_sq_i    (cmt_squash_i[t]),
      .cmt_pc_i    (cmt_target_i[t*PC_W +: PC_W]),
      .rob_i       (rob_busy_i[t]),
      .dec_sq_i    (dec_squash_i[t]),
      .dec_pc_i    (dec_target_i[t*PC_W +: PC_W]),
      .issue_i     (issue_i[t]),
      .issue_tag_i (issue_tag_i[t*TAG_W +: TAG_W]),
      .take_i      (line_taken_i[t]),
      .rsp_i       (rsp_here),
      .rsp_tag_i   (rsp_tag_i),
      .status_o    (st),
      .pc_o        (pc_o[t*PC_W +: PC_W]),
      .npc_o       (npc_o[t*PC_W +: PC_W]),
      .accept_o    (accept[t]),
      .changed_o   (changed[t])
    );

    assign status_o[t*3 +: 3] = st;
    assign stalled_o[t]       = |bits;
    assign thr_active[t]      = (st == ST_RUN) || (st == ST_SQUASH) || (st == ST_CDONE);
  end

  fsc_drop_count #(.CNT_W(CNT_W)) u_drop (
    .clk    (clk),
    .rst_n  (rst_n),
    .drop_i (rsp_valid_i && (accept == '0)),
    .cnt_o  (drop_cnt_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= |changed;
  end

  assign status_chg_o   = chg_q;
  assign stage_active_o = |thr_active;

  assert_chg_matches_R12: assert property (@(posedge clk) disable iff (!rst_n)
    status_chg_o |-> (status_o != $past(status_o)));

  assert_one_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept));
endmodule

// File: tb/fetch_status_ctrl_test.sv
`timescale 1ns/1ps
module fetch_status_ctrl_test;
  localparam int NT = 2, PC_W = 16, TAG_W = 3, CNT_W = 3, TID_W = 1;
  localparam logic [PC_W-1:0] RPC = 16'h0040;
  localparam logic [2:0] RUN = 3'd0, SQ = 3'd2, BLK = 3'd3, CW = 3'd4, CD = 3'd5;

  logic clk = 1'b0;
  logic rst_n;
  logic ctx;
  logic [NT*4-1:0] blk, rel;
  logic [NT-1:0] csq, rob, dsq, iss, take;
  logic [NT*PC_W-1:0] ctgt, dtgt;
  logic [NT*TAG_W-1:0] itag;
  logic rv;
  logic [TID_W-1:0] rtid;
  logic [TAG_W-1:0] rtag;
  logic [NT*3-1:0] st;
  logic [NT*PC_W-1:0] pc, npc;
  logic [NT-1:0] stl;
  logic chg, act;
  logic [CNT_W-1:0] drop;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_status_ctrl #(.NT(NT), .PC_W(PC_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .RESET_PC(RPC)) uut (
    .clk(clk), .rst_n(rst_n), .ctx_switch_i(ctx), .stage_block_i(blk), .stage_release_i(rel),
    .cmt_squash_i(csq), .cmt_target_i(ctgt), .rob_busy_i(rob), .dec_squash_i(dsq),
    .dec_target_i(dtgt), .issue_i(iss), .issue_tag_i(itag), .line_taken_i(take),
    .rsp_valid_i(rv), .rsp_tid_i(rtid), .rsp_tag_i(rtag), .status_o(st), .pc_o(pc),
    .npc_o(npc), .stalled_o(stl), .status_chg_o(chg), .stage_active_o(act), .drop_cnt_o(drop));

  task automatic chk(input logic [31:0] a, input logic [31:0] e, input string what);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, a, e);
    end
  endtask

  task automatic quiet();
    ctx = 0; blk = '0; rel = '0; csq = '0; rob = '0; dsq = '0; iss = '0; take = '0;
    ctgt = '0; dtgt = '0; itag = '0; rv = 0; rtid = '0; rtag = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    quiet(); rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  function automatic logic [2:0] s_of(input int t);
    return st[t*3 +: 3];
  endfunction

  function automatic logic [PC_W-1:0] pc_of(input int t);
    return pc[t*PC_W +: PC_W];
  endfunction

  function automatic logic [2:0] exp_st(input bit from_sq, input bit c, input bit r, input bit d, input bit s);
    if (c || r) return SQ;
    if (d && !from_sq) return SQ;
    if (s) return BLK;
    return RUN;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    do_reset();
    // R1 reset state
    chk(st, '0, "R1 status");
    chk(pc_of(0), RPC, "R1 pc t0");
    chk(npc[PC_W-1:0], RPC + 4, "R1 npc t0");
    chk(stl, '0, "R1 stall bits");
    chk(drop, '0, "R1 drop");
    chk(chg, 0, "R1 chg");
    chk(act, 1, "R11 active after reset");

    // Sweep of priority: R3 R4 R5 R6 R7
    for (int from_sq = 0; from_sq < 2; from_sq++) begin
      for (int k = 0; k < 16; k++) begin
        logic [PC_W-1:0] base, epc;
        bit c, r, d, s;
        c = k[0]; r = k[1]; d = k[2]; s = k[3];
        do_reset();
        base = RPC;
        if (from_sq != 0) begin
          csq[0] = 1; ctgt[0 +: PC_W] = 16'h0100; step(); quiet(); base = 16'h0100;
        end
        csq[0] = c; rob[0] = r; dsq[0] = d; ctx = s;
        ctgt[0 +: PC_W] = 16'h0200; dtgt[0 +: PC_W] = 16'h0300;
        step();
        epc = c ? 16'h0200 : ((d && !r && from_sq == 0) ? 16'h0300 : base);
        chk(s_of(0), exp_st(from_sq != 0, c, r, d, s), $sformatf("R3 R4 R5 R6 R7 status k=%0d sq=%0d", k, from_sq));
        chk(pc_of(0), epc, $sformatf("R3 R5 pc k=%0d sq=%0d", k, from_sq));
        chk(npc[PC_W-1:0], epc + 4, $sformatf("R3 npc k=%0d sq=%0d", k, from_sq));
        chk(s_of(1), s ? BLK : RUN, $sformatf("R6 ctx stalls t1 k=%0d", k));
        quiet();
      end
    end

    // R2 sticky stall bits
    do_reset();
    blk[1] = 1; step(); quiet();
    chk(s_of(0), BLK, "R2 block rename");
    chk(stl[0], 1, "R2 bit held");
    step();
    chk(s_of(0), BLK, "R2 stays blocked");
    chk(chg, 0, "R12 no change");
    blk[0] = 1; blk[3] = 1; rel[1] = 1; step(); quiet();
    chk(s_of(0), BLK, "R2 other bits hold stall");
    rel[0] = 1; step(); quiet();
    chk(s_of(0), BLK, "R2 commit bit still set");
    rel[3] = 1; step(); quiet();
    chk(s_of(0), RUN, "R2 R7 all released");
    chk(stl[0], 0, "R2 bits clear");
    chk(chg, 1, "R12 change seen");
    step();
    chk(chg, 0, "R12 change cleared");

    // Cache path R6 R8 R9 R10 R11
    do_reset();
    iss[0] = 1; itag[0 +: TAG_W] = 3'd5; blk[4] = 1; step(); quiet();
    chk(s_of(0), CW, "R8 issue to wait");
    chk(s_of(1), BLK, "R2 t1 blocked");
    chk(act, 0, "R11 wait and blocked inactive");
    ctx = 1; step();
    chk(s_of(0), CW, "R6 wait not blocked");
    rv = 1; rtid = 0; rtag = 3'd6; step();
    chk(s_of(0), CW, "R10 mismatch ignored");
    chk(drop, 1, "R10 mismatch counted");
    rtag = 3'd5; step(); quiet();
    chk(s_of(0), BLK, "R9 stalled response to blocked");
    chk(drop, 1, "R9 accepted not counted");
    step();
    chk(s_of(0), RUN, "R7 resume");
    iss[0] = 1; itag[0 +: TAG_W] = 3'd2; step(); quiet();
    rv = 1; rtid = 0; rtag = 3'd2; step(); quiet();
    chk(s_of(0), CD, "R9 response to done");
    chk(act, 1, "R11 done active");
    step();
    chk(s_of(0), CD, "R8 done holds");
    take[0] = 1; step(); quiet();
    chk(s_of(0), RUN, "R8 taken to running");
    iss[0] = 1; itag[0 +: TAG_W] = 3'd3; step(); quiet();
    dsq[0] = 1; dtgt[0 +: PC_W] = 16'h0440; step(); quiet();
    chk(s_of(0), SQ, "R10 squash in wait");
    chk(pc_of(0), 16'h0440, "R5 redirect");
    rv = 1; rtid = 0; rtag = 3'd3; step(); quiet();
    chk(s_of(0), RUN, "R10 late response ignored");
    chk(drop, 2, "R10 late response counted");
    rv = 1; rtid = 1; rtag = 3'd0; step(); quiet();
    chk(s_of(1), BLK, "R10 response to blocked t1 ignored");
    chk(drop, 3, "R10 counted t1");
    csq[1] = 1; ctgt[PC_W +: PC_W] = 16'h0abc; step(); quiet();
    chk(s_of(1), SQ, "R3 t1 squash");
    chk(pc_of(1), 16'h0abc, "R3 t1 pc");
    chk(pc_of(0), 16'h0440, "R3 t0 untouched");
    for (int i = 0; i < 8; i++) begin
      rv = 1; rtid = 0; rtag = 3'd7; step();
    end
    quiet();
    chk(drop, 7, "R10 saturate");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule